// File: doc/BRIEF.md
# Parallel Bus Burst Read Master

This block sits on the host side of a parallel bus and pulls data out of an asynchronous peripheral using back-to-back reads. Software-side logic hands it one request at a time: a start word address, a count of reads and a width flag that selects 32-bit or 16-bit transfers. The master lowers its chip-select and read strobes together, presents the address, and captures the data bus once enough clock cycles have gone by for the peripheral's data to be valid. It then steps the low address field and reads again, all without releasing the strobes.

All nanosecond limits are turned into clock-cycle counts by rounding up against a clock-period parameter. A burst stays inside one 32-byte window, so the upper address field never moves while the strobes are low. This gives at most 8 reads per burst in 32-bit mode and at most 16 in 16-bit mode. A longer request is split into several bursts, with the strobes held high for the minimum gap between them. Each captured word leaves on a valid/ready stream, and the final word of a request is flagged. When the consumer stalls, the master holds its current address and does not capture.

Top module: `pio_burst_reader`

## Requirements
- R1: `req_ready` is high only while the master is idle with both strobes high. A request with `req_len` of 0 is taken and discarded: it causes no strobe activity and no output word.
- R2: `bus_cs_n` and `bus_rd_n` always carry the same value. They fall together and rise together.
- R3: While the strobes stay low, the master performs at most 8 reads in 32-bit mode and at most 16 reads in 16-bit mode.
- R4: While the strobes stay low, `bus_addr[6:4]` (byte address bits 7 to 5) does not change. Only `bus_addr[3:0]` (byte address bits 4 to 1) moves.
- R5: `bus_addr` carries byte address bits 7 to 1. Within a burst it rises by 1 per read in 16-bit mode and by 2 per read in 32-bit mode. In 32-bit mode `req_addr[0]` is treated as 0.
- R6: A word is captured no sooner than ceil(30 ns / period) cycles after the strobes fall, and no sooner than ceil(40 ns / period) cycles after its address was applied.
- R7: Within a burst, each address is held for at least ceil(45 ns / period) cycles before the next one is applied.
- R8: Between any two bursts, within one request or across requests, the strobes stay high for at least ceil(13 ns / period) cycles.
- R9: A request for N reads returns exactly N words, in ascending address order with 7-bit wrap. When a window boundary is reached, the master starts a new burst at the next address.
- R10: In 16-bit mode `out_data[31:16]` is 0 and `out_data[15:0]` equals the bus bits 15 to 0. In 32-bit mode `out_data` equals the full bus.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged. No new word is captured while the output holds a word that has not been taken.
- R12: `out_last` is high on the final word of a request and low on every other word.
- R13: During and right after reset, both strobes are high, `out_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_addr | input | 7 | Start word address (byte address bits 7 to 1) |
| req_len | input | 8 | Number of reads |
| req_wide | input | 1 | 1 selects 32-bit reads, 0 selects 16-bit reads |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word at this edge |
| out_data | output | 32 | Captured word |
| out_last | output | 1 | Final word of the request |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read enable, active low |
| bus_addr | output | 7 | Address lines, byte address bits 7 to 1 |
| bus_data | input | 32 | Data lines from the peripheral |

## Verification
The assertions assume that the clock-period parameter matches the real clock. They also assume that the consumer follows the stream rule, so a word counts as moved only at an edge where `out_valid` and `out_ready` are both high. The stimulus keeps to this by driving `req_valid` steady until acceptance and by changing `out_ready` only away from the clock edge. The bench's peripheral model drives a garbage value until the strobe-based delay and the address-based delay have both elapsed, counted in whole clock periods. In 16-bit mode it always drives noise on the upper data lines, so an early capture or an unmasked half word shows up as a data mismatch.

// File: rtl/pio_burst_pkg.sv
package pio_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_STEP,
        ST_GAP
    } rd_state_e;

    // round a nanosecond limit up to whole clock periods
    function automatic int ns_to_cyc(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pio_addr_step.sv
module pio_addr_step #(
    parameter int ADDR_W = 7,
    parameter int LOW_W  = 4
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              wide,
    output logic [ADDR_W-1:0] nxt,
    output logic              win_end
);
    logic [ADDR_W-1:0] step;

    always_comb begin
        step    = wide ? ADDR_W'(2) : ADDR_W'(1);
        nxt     = cur + step;
        // the next step would leave the window of the fixed upper field
        win_end = wide ? (&cur[LOW_W-1:1]) : (&cur[LOW_W-1:0]);
    end
endmodule

// File: rtl/pio_out_reg.sv
module pio_out_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              last_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              slot_free
);
    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] data;
        logic              last;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d    = slot_q;
        slot_free = !slot_q.v || out_ready;
        if (slot_q.v && out_ready) slot_d.v = 1'b0;
        if (load) begin
            slot_d.v    = 1'b1;
            slot_d.data = din;
            slot_d.last = last_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign out_valid = slot_q.v;
    assign out_data  = slot_q.data;
    assign out_last  = slot_q.last;

    assert_no_overwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!out_valid || out_ready));

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: rtl/pio_burst_reader.sv
module pio_burst_reader
    import pio_burst_pkg::*;
#(
    parameter int ADDR_W        = 7,
    parameter int LOW_W         = 4,
    parameter int LEN_W         = 8,
    parameter int DATA_W        = 32,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_CSDV_NS     = 30,
    parameter int T_ADV_NS      = 40,
    parameter int T_ACYC_NS     = 45,
    parameter int T_CSH_NS      = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_wide,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data
);
    localparam int CS_DV_C    = ns_to_cyc(T_CSDV_NS, CLK_PERIOD_NS);
    localparam int A_DV_C     = ns_to_cyc(T_ADV_NS, CLK_PERIOD_NS);
    localparam int DV_C       = imax(1, imax(CS_DV_C, A_DV_C));
    localparam int ACYC_C     = ns_to_cyc(T_ACYC_NS, CLK_PERIOD_NS);
    localparam int HOLD_C     = imax(ACYC_C, DV_C);
    localparam int CSH_C      = imax(1, ns_to_cyc(T_CSH_NS, CLK_PERIOD_NS));
    localparam int TIM_W      = $clog2(imax(HOLD_C, CSH_C) + 1);
    localparam int NARROW_MAX = 1 << LOW_W;
    localparam int WIDE_MAX   = 1 << (LOW_W - 1);
    localparam int BC_W       = LOW_W + 1;
    localparam int HALF       = DATA_W / 2;

    typedef struct packed {
        rd_state_e         st;
        logic              cs_n;
        logic              rd_n;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [BC_W-1:0]   bcnt;
        logic [TIM_W-1:0]  tim;
        logic              wide;
    } fsm_t;

    fsm_t q, n;

    logic              load, last_w, slot_free, win_end, burst_full, end_burst;
    logic [ADDR_W-1:0] nxt;
    logic [DATA_W-1:0] cap_data;

    pio_addr_step #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_step (
        .cur     (q.addr),
        .wide    (q.wide),
        .nxt     (nxt),
        .win_end (win_end)
    );

    pio_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .din       (cap_data),
        .last_in   (last_w),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .slot_free (slot_free)
    );

    always_comb begin
        n          = q;
        load       = 1'b0;
        last_w     = 1'b0;
        cap_data   = q.wide ? bus_data : {{HALF{1'b0}}, bus_data[HALF-1:0]};
        burst_full = q.wide ? (q.bcnt == BC_W'(WIDE_MAX - 1))
                            : (q.bcnt == BC_W'(NARROW_MAX - 1));
        end_burst  = (q.rem == LEN_W'(1)) || burst_full || win_end;
        case (q.st)
            ST_IDLE: begin
                if (req_valid && req_len != '0) begin
                    n.wide = req_wide;
                    n.addr = req_wide ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
                    n.rem  = req_len;
                    n.bcnt = '0;
                    n.tim  = '0;
                    n.cs_n = 1'b0;
                    n.rd_n = 1'b0;
                    n.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (q.tim != TIM_W'(DV_C - 1)) begin
                    n.tim = q.tim + 1'b1;
                end else if (slot_free) begin
                    load   = 1'b1;
                    last_w = (q.rem == LEN_W'(1));
                    n.rem  = q.rem - 1'b1;
                    if (end_burst) begin
                        n.cs_n = 1'b1;
                        n.rd_n = 1'b1;
                        n.addr = nxt;
                        n.bcnt = '0;
                        n.tim  = '0;
                        n.st   = ST_GAP;
                    end else if (HOLD_C == DV_C) begin
                        n.addr = nxt;
                        n.bcnt = q.bcnt + 1'b1;
                        n.tim  = '0;
                    end else begin
                        n.bcnt = q.bcnt + 1'b1;
                        n.tim  = q.tim + 1'b1;
                        n.st   = ST_STEP;
                    end
                end
            end
            ST_STEP: begin
                if (q.tim == TIM_W'(HOLD_C - 1)) begin
                    n.addr = nxt;
                    n.tim  = '0;
                    n.st   = ST_WAIT;
                end else begin
                    n.tim = q.tim + 1'b1;
                end
            end
            ST_GAP: begin
                if (q.tim == TIM_W'(CSH_C - 1)) begin
                    n.tim = '0;
                    if (q.rem != '0) begin
                        n.cs_n = 1'b0;
                        n.rd_n = 1'b0;
                        n.st   = ST_WAIT;
                    end else begin
                        n.st = ST_IDLE;
                    end
                end else begin
                    n.tim = q.tim + 1'b1;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
            q.rd_n <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign bus_cs_n  = q.cs_n;
    assign bus_rd_n  = q.rd_n;
    assign bus_addr  = q.addr;

    // ---------------- checking logic ----------------
    localparam int CK_W = 8;
    logic [CK_W-1:0]   burst_reads_q, low_age_q, addr_age_q, hi_run_q;
    logic [ADDR_W-1:0] prev_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_reads_q <= '0;
            low_age_q     <= '0;
            addr_age_q    <= '0;
            hi_run_q      <= '1;
            prev_addr_q   <= '0;
        end else begin
            prev_addr_q <= bus_addr;
            if (bus_cs_n)  burst_reads_q <= '0;
            else if (load) burst_reads_q <= burst_reads_q + 1'b1;
            if (bus_cs_n)              low_age_q <= '0;
            else if (low_age_q != '1)  low_age_q <= low_age_q + 1'b1;
            if (bus_addr != prev_addr_q) addr_age_q <= '0;
            else if (addr_age_q != '1)   addr_age_q <= addr_age_q + 1'b1;
            if (!bus_cs_n)            hi_run_q <= '0;
            else if (hi_run_q != '1)  hi_run_q <= hi_run_q + 1'b1;
        end
    end

    assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && bus_rd_n));

    assert_burst_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> (burst_reads_q <= (q.wide ? CK_W'(WIDE_MAX) : CK_W'(NARROW_MAX))));

    assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !$past(bus_cs_n)) |->
            (bus_addr[ADDR_W-1:LOW_W] == $past(bus_addr[ADDR_W-1:LOW_W])));

    assert_capture_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!bus_cs_n && low_age_q >= CK_W'(DV_C - 1)));

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !$past(bus_cs_n) && bus_addr != prev_addr_q) |->
            (addr_age_q >= CK_W'(ACYC_C - 1)));

    assert_gap_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> (hi_run_q >= CK_W'(CSH_C)));
endmodule

// File: tb/sim_pio_burst_reader.sv
module sim_pio_burst_reader;
    localparam int CLK_NS   = 10;
    localparam int CSH_CYC  = (13 + CLK_NS - 1) / CLK_NS;
    localparam int ACYC_CYC = (45 + CLK_NS - 1) / CLK_NS;

    logic        clk, rst_n;
    logic        req_valid, req_ready, req_wide;
    logic [6:0]  req_addr;
    logic [7:0]  req_len;
    logic        out_valid, out_ready, out_last;
    logic [31:0] out_data, bus_data;
    logic        bus_cs_n, bus_rd_n;
    logic [6:0]  bus_addr;

    int checks = 0;
    int fails  = 0;
    int falls  = 0;
    int stall_mode = 0;
    bit cur_wide = 1'b1;
    logic [31:0] exp_data[$];
    bit          exp_last[$];

    pio_burst_reader #(.CLK_PERIOD_NS(CLK_NS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_wide(req_wide),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_addr(bus_addr), .bus_data(bus_data)
    );

    initial clk = 1'b0;
    always #(CLK_NS / 2) clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [6:0] a);
        return {1'b0, a, 8'hA5 ^ {1'b0, a}, ~{1'b0, a}, 8'h3C + {1'b0, a}};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // peripheral model and per-cycle comparison, all on the falling edge
    int          cs_run, a_run, hi_run, bcount;
    logic        prev_cs;
    logic [6:0]  prev_addr;
    bit          hold_pend;
    logic [31:0] hold_data;
    logic        hold_last;

    always @(negedge clk) begin
        if (!rst_n) begin
            out_ready = 1'b1;
            bus_data  = 32'h0;
            prev_cs   = 1'b1;
            prev_addr = '0;
            hi_run    = 100;
            cs_run    = 0;
            a_run     = 0;
            bcount    = 0;
            hold_pend = 1'b0;
        end else begin
            check(bus_cs_n == bus_rd_n, "R2 strobes paired", {31'b0, bus_rd_n}, {31'b0, bus_cs_n});
            if (!bus_cs_n) begin
                if (prev_cs) begin
                    falls++;
                    check(hi_run >= CSH_CYC, "R8 gap", hi_run, CSH_CYC);
                    bcount = 1;
                    cs_run = 1;
                    a_run  = 1;
                end else begin
                    cs_run++;
                    if (bus_addr != prev_addr) begin
                        check(a_run >= ACYC_CYC, "R7 address hold", a_run, ACYC_CYC);
                        check(bus_addr[6:4] == prev_addr[6:4], "R4 upper field", {25'b0, bus_addr}, {25'b0, prev_addr});
                        check(bus_addr == 7'(prev_addr + (cur_wide ? 2 : 1)), "R5 step",
                              {25'b0, bus_addr}, {25'b0, 7'(prev_addr + (cur_wide ? 2 : 1))});
                        bcount++;
                        check(bcount <= (cur_wide ? 8 : 16), "R3 burst limit", bcount, cur_wide ? 8 : 16);
                        a_run = 1;
                    end else begin
                        a_run++;
                    end
                end
                hi_run = 0;
            end else begin
                hi_run++;
                cs_run = 0;
            end
            prev_cs   = bus_cs_n;
            prev_addr = bus_addr;

            // data is garbage until both valid delays have passed by the next edge
            if (!bus_cs_n && cs_run * CLK_NS >= 30 && a_run * CLK_NS >= 40)
                bus_data = mem_word(bus_addr);
            else
                bus_data = 32'hBAD0_0000 | 32'($urandom_range(0, 65535));
            if (!cur_wide) bus_data[31:16] = 16'($urandom);

            out_ready = (stall_mode != 0) ? 1'($urandom_range(0, 1)) : 1'b1;

            if (hold_pend)
                check(out_valid && out_data == hold_data && out_last == hold_last,
                      "R11 output held", out_data, hold_data);
            hold_pend = out_valid && !out_ready;
            hold_data = out_data;
            hold_last = out_last;

            if (out_valid && out_ready) begin
                if (exp_data.size() == 0) begin
                    check(1'b0, "R9 unexpected word", out_data, 32'h0);
                end else begin
                    logic [31:0] ed;
                    bit el;
                    ed = exp_data.pop_front();
                    el = exp_last.pop_front();
                    check(out_data == ed, "R6 R9 R10 data", out_data, ed);
                    check(out_last == el, "R12 last flag", {31'b0, out_last}, {31'b0, el});
                end
            end
        end
    end

    task automatic send(input logic [6:0] a, input int len, input bit wide);
        logic [6:0] base;
        @(negedge clk);
        req_addr  = a;
        req_len   = 8'(len);
        req_wide  = wide;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        cur_wide = wide;
        base = wide ? {a[6:1], 1'b0} : a;
        for (int i = 0; i < len; i++) begin
            logic [6:0]  ad;
            logic [31:0] w;
            ad = 7'(base + (wide ? 2 * i : i));
            w  = mem_word(ad);
            if (!wide) w[31:16] = 16'h0;
            exp_data.push_back(w);
            exp_last.push_back(i == len - 1);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle;
        int n = 0;
        while ((exp_data.size() != 0 || !req_ready) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(n < 5000, "R9 request completes", n, 5000);
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        req_len   = '0;
        req_wide  = 1'b1;
        repeat (4) @(negedge clk);
        check(bus_cs_n && bus_rd_n && !out_valid && req_ready, "R13 reset state",
              {28'b0, bus_cs_n, bus_rd_n, out_valid, req_ready}, 32'hD);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_cs_n && !out_valid && req_ready, "R13 after release",
              {29'b0, bus_cs_n, out_valid, req_ready}, 32'h5);

        begin
            int f0;
            // full 32-bit window in one burst
            f0 = falls;
            send(7'h00, 8, 1'b1);
            wait_idle();
            check(falls - f0 == 1, "R3 R9 one wide burst", falls - f0, 1);
            // full 16-bit window in one burst
            f0 = falls;
            send(7'h00, 16, 1'b0);
            wait_idle();
            check(falls - f0 == 1, "R3 R9 one narrow burst", falls - f0, 1);
            // window crossing: 11 reads then 9 reads
            f0 = falls;
            send(7'h05, 20, 1'b0);
            wait_idle();
            check(falls - f0 == 2, "R9 split at window", falls - f0, 2);
            // odd start in 32-bit mode is aligned down
            send(7'h13, 10, 1'b1);
            wait_idle();
            // long request with a stalling consumer: 5 wide bursts
            stall_mode = 1;
            f0 = falls;
            send(7'h20, 40, 1'b1);
            wait_idle();
            check(falls - f0 == 5, "R3 R9 long split", falls - f0, 5);
            // wrap around the top of the address range
            f0 = falls;
            send(7'h7C, 6, 1'b0);
            wait_idle();
            check(falls - f0 == 2, "R9 address wrap", falls - f0, 2);
            // zero length request leaves the bus alone
            stall_mode = 0;
            send(7'h10, 0, 1'b1);
            begin
                bit quiet = 1'b1;
                repeat (12) begin
                    @(negedge clk);
                    if (!bus_cs_n || out_valid || !req_ready) quiet = 1'b0;
                end
                check(quiet, "R1 zero length ignored", {31'b0, quiet}, 32'h1);
            end
            // mixed random requests issued back to back
            stall_mode = 1;
            for (int k = 0; k < 8; k++)
                send(7'($urandom_range(0, 127)), $urandom_range(1, 40), 1'($urandom_range(0, 1)));
            wait_idle();
            check(exp_data.size() == 0, "R9 all words returned", exp_data.size(), 0);
        end
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule